// File: doc/BRIEF.md
# Floating-point operate word decoder

This block examines a 32-bit floating-point operate instruction word and says what it is. It picks out whether the word is a register-to-register arithmetic operation or a compare, and names the operation kind. It gives the precision each of the three operand slots is used at and the three five-bit register indices. It then checks every index against the precision of its slot. The result is a one-bit failure cause for an unknown operation field, a one-bit failure cause for an illegal register, and a three-bit trap code for a status field.

The decode itself is combinational. The result is captured on the rising clock edge on which `in_valid` is high and held until the next accepted word. A trap handler or an operation sequencer would use the registered fields to pick operand registers and an execution unit, or to raise a fault. Arithmetic is not performed here.

Top module: `fpop_decoder`

## Requirements
- R1: A word is in the arithmetic class when `(in_word & 0xC1F80000) == 0x81A00000` and in the compare class when the masked value is `0x81A80000`. Any other word is reported as unknown (`out_err_unknown`=1).
- R2: The operation field is `in_word[13:5]`. A value not listed for the word's class gives `out_err_unknown`=1 with kind 0, all three precisions 0, `out_rd_cc`=0, `out_err_badreg`=0 and trap 0. No register check is made for such a word.
- R3: `out_kind` encoding: 0 none, 1 move, 2 negate, 3 absolute, 4 add, 5 subtract, 6 multiply, 7 divide, 8 square root, 9 widening multiply, 10 convert, 11 compare, 12 compare-with-exception. Precision codes are 00 unused, 01 single, 10 double, 11 quad. The arithmetic class opcodes are:
  - 0x001, 0x005, 0x009: move, negate and absolute on singles, with rs1 unused.
  - 0x029, 0x02A, 0x02B: square root at S, D and Q, with rs1 unused.
  - 0x041..0x043 add, 0x045..0x047 subtract, 0x049..0x04B multiply and 0x04D..0x04F divide. The low two bits 01, 10 and 11 give S, D and Q for all three operands.
  - 0x069: widening multiply, S,S to D. 0x06E: widening multiply, D,D to Q.
  - Converts (rs2 to rd, rs1 unused): 0x0C6 D to S, 0x0C7 Q to S, 0x0C9 S to D, 0x0CB Q to D, 0x0CC S to Q, 0x0CD S to Q, 0x0CE D to Q, 0x0D1 S to S, 0x0D2 D to S, 0x0D3 Q to S.
- R4: `out_idx_rs1` is `in_word[18:14]`, `out_idx_rs2` is `in_word[4:0]` and `out_idx_rd` is `in_word[29:25]`, for every accepted word.
- R5: An operand used at quad precision whose index has either of its two low bits set is illegal.
- R6: An operand used at double precision whose index has bit 0 set is illegal.
- R7: The compare class opcodes are 0x051, 0x052, 0x053 (compare at S, D, Q) and 0x055, 0x056, 0x057 (compare-with-exception at S, D, Q). For these, rs1 and rs2 have that precision, rd precision is 00 and `out_rd_cc`=1. An rd field other than 0 is illegal.
- R8: An accepted word with any illegal register gives `out_err_badreg`=1 and trap code 6. Every other accepted word sets the trap code to 0, so the code is cleared on each decode.
- R9: Outputs change only on the rising edge that samples `in_valid`=1, one cycle after the word is presented. `out_valid` is high for exactly the cycle after each accepted word, and all other outputs hold between accepted words.
- R10: While `rst_n` is low every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_word` is to be decoded |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Registered result was updated in the previous edge |
| out_kind | output | 4 | Operation kind code |
| out_prec_rs1 | output | 2 | Precision of rs1 |
| out_prec_rs2 | output | 2 | Precision of rs2 |
| out_prec_rd | output | 2 | Precision of rd (00 for compares) |
| out_idx_rs1 | output | 5 | rs1 register index |
| out_idx_rs2 | output | 5 | rs2 register index |
| out_idx_rd | output | 5 | rd register index |
| out_rd_cc | output | 1 | Destination is the condition codes |
| out_err_unknown | output | 1 | Word not recognised |
| out_err_badreg | output | 1 | Illegal register index |
| out_trap | output | 3 | Trap code for the status field |

## Verification
The class and opcode lookup and the register legality check can both apply to one word. A word with an unlisted operation field can also carry misaligned indices. The bench drives such words and expects only the unknown cause, with trap 0. Several alignment faults can also fall in the same word, for example a quad compare with both a misaligned source and a nonzero rd field. The reference model expects exactly one error cause and trap code 6 however many faults coincide. Idle cycles between these words check that nothing changes without a strobe.

// File: rtl/fpop_pkg.sv
package fpop_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned IDX_W    = 5;
   localparam int unsigned OPF_W    = 9;
   localparam int unsigned OPF_LSB  = 5;
   localparam int unsigned RS1_LSB  = 14;
   localparam int unsigned RS2_LSB  = 0;
   localparam int unsigned RD_LSB   = 25;
   localparam int unsigned N_OPND   = 3;

   localparam logic [WORD_W-1:0] CLASS_MASK = 32'hC1F8_0000;
   localparam logic [WORD_W-1:0] ARITH_SIG  = 32'h81A0_0000;
   localparam logic [WORD_W-1:0] CMP_SIG    = 32'h81A8_0000;

   typedef enum logic [1:0] {
      PREC_NONE = 2'b00,
      PREC_S    = 2'b01,
      PREC_D    = 2'b10,
      PREC_Q    = 2'b11
   } prec_e;

   typedef enum logic [3:0] {
      K_NONE = 4'd0,
      K_MOV  = 4'd1,
      K_NEG  = 4'd2,
      K_ABS  = 4'd3,
      K_ADD  = 4'd4,
      K_SUB  = 4'd5,
      K_MUL  = 4'd6,
      K_DIV  = 4'd7,
      K_SQRT = 4'd8,
      K_WMUL = 4'd9,
      K_CVT  = 4'd10,
      K_CMP  = 4'd11,
      K_CMPX = 4'd12
   } kind_e;

   typedef struct packed {
      logic  hit;
      kind_e kind;
      prec_e p_rs1;
      prec_e p_rs2;
      prec_e p_rd;
   } entry_t;

   function automatic entry_t mk(kind_e k, prec_e a, prec_e b, prec_e d);
      entry_t e;
      e.hit   = 1'b1;
      e.kind  = k;
      e.p_rs1 = a;
      e.p_rs2 = b;
      e.p_rd  = d;
      return e;
   endfunction

   function automatic prec_e low_prec(logic [1:0] sel);
      prec_e p;
      case (sel)
         2'b01:   p = PREC_S;
         2'b10:   p = PREC_D;
         2'b11:   p = PREC_Q;
         default: p = PREC_NONE;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/fpop_class_match.sv
module fpop_class_match
   import fpop_pkg::*;
#(
   parameter int unsigned W = WORD_W
) (
   input  logic [W-1:0] word,
   output logic         is_arith,
   output logic         is_cmp
);

   generate
      if (W != 32) begin : g_bad_w
         $error("fpop_class_match: word width must be 32");
      end
   endgenerate

   logic [W-1:0] masked;

   always_comb begin
      masked   = word & CLASS_MASK;
      is_arith = (masked == ARITH_SIG);
      is_cmp   = (masked == CMP_SIG);
   end

endmodule

// File: rtl/fpop_opf_table.sv
module fpop_opf_table
   import fpop_pkg::*;
#(
   parameter int unsigned OW = OPF_W
) (
   input  logic          is_arith,
   input  logic          is_cmp,
   input  logic [OW-1:0] opf,
   output entry_t        entry
);

   generate
      if (OW != 9) begin : g_bad_ow
         $error("fpop_opf_table: operation field must be 9 bits");
      end
   endgenerate

   entry_t arith_e;
   entry_t cmp_e;

   // Arithmetic class lookup. Families with a precision in the two low
   // opcode bits share one arm and derive the precision from those bits.
   always_comb begin
      arith_e = '0;
      case (opf)
         9'h001: arith_e = mk(K_MOV, PREC_NONE, PREC_S, PREC_S);
         9'h005: arith_e = mk(K_NEG, PREC_NONE, PREC_S, PREC_S);
         9'h009: arith_e = mk(K_ABS, PREC_NONE, PREC_S, PREC_S);
         9'h029, 9'h02A, 9'h02B:
            arith_e = mk(K_SQRT, PREC_NONE, low_prec(opf[1:0]), low_prec(opf[1:0]));
         9'h041, 9'h042, 9'h043:
            arith_e = mk(K_ADD, low_prec(opf[1:0]), low_prec(opf[1:0]), low_prec(opf[1:0]));
         9'h045, 9'h046, 9'h047:
            arith_e = mk(K_SUB, low_prec(opf[1:0]), low_prec(opf[1:0]), low_prec(opf[1:0]));
         9'h049, 9'h04A, 9'h04B:
            arith_e = mk(K_MUL, low_prec(opf[1:0]), low_prec(opf[1:0]), low_prec(opf[1:0]));
         9'h04D, 9'h04E, 9'h04F:
            arith_e = mk(K_DIV, low_prec(opf[1:0]), low_prec(opf[1:0]), low_prec(opf[1:0]));
         9'h069: arith_e = mk(K_WMUL, PREC_S, PREC_S, PREC_D);
         9'h06E: arith_e = mk(K_WMUL, PREC_D, PREC_D, PREC_Q);
         9'h0C6: arith_e = mk(K_CVT, PREC_NONE, PREC_D, PREC_S);
         9'h0C7: arith_e = mk(K_CVT, PREC_NONE, PREC_Q, PREC_S);
         9'h0C9: arith_e = mk(K_CVT, PREC_NONE, PREC_S, PREC_D);
         9'h0CB: arith_e = mk(K_CVT, PREC_NONE, PREC_Q, PREC_D);
         9'h0CC: arith_e = mk(K_CVT, PREC_NONE, PREC_S, PREC_Q);
         9'h0CD: arith_e = mk(K_CVT, PREC_NONE, PREC_S, PREC_Q);
         9'h0CE: arith_e = mk(K_CVT, PREC_NONE, PREC_D, PREC_Q);
         9'h0D1: arith_e = mk(K_CVT, PREC_NONE, PREC_S, PREC_S);
         9'h0D2: arith_e = mk(K_CVT, PREC_NONE, PREC_D, PREC_S);
         9'h0D3: arith_e = mk(K_CVT, PREC_NONE, PREC_Q, PREC_S);
         default: arith_e = '0;
      endcase
   end

   // Compare class lookup; the destination is always the condition codes.
   always_comb begin
      cmp_e = '0;
      case (opf)
         9'h051, 9'h052, 9'h053:
            cmp_e = mk(K_CMP, low_prec(opf[1:0]), low_prec(opf[1:0]), PREC_NONE);
         9'h055, 9'h056, 9'h057:
            cmp_e = mk(K_CMPX, low_prec(opf[1:0]), low_prec(opf[1:0]), PREC_NONE);
         default: cmp_e = '0;
      endcase
   end

   always_comb begin
      if (is_arith)    entry = arith_e;
      else if (is_cmp) entry = cmp_e;
      else             entry = '0;
   end

endmodule

// File: rtl/fpop_reg_check.sv
module fpop_reg_check
   import fpop_pkg::*;
#(
   parameter int unsigned IW      = IDX_W,
   parameter bit          IS_DEST = 1'b0
) (
   input  logic          active,
   input  logic [1:0]    prec,
   input  logic [IW-1:0] idx,
   output logic          bad,
   output logic          to_cc
);

   generate
      if (IW < 2) begin : g_bad_iw
         $error("fpop_reg_check: index must be at least 2 bits");
      end
   endgenerate

   logic align_bad;
   logic cc_bad;

   always_comb begin
      case (prec)
         PREC_Q:  align_bad = |idx[1:0];
         PREC_D:  align_bad = idx[0];
         default: align_bad = 1'b0;
      endcase
   end

   generate
      if (IS_DEST) begin : g_dest
         // An unused destination slot means the condition codes, of which
         // only set 0 exists.
         always_comb begin
            to_cc  = active && (prec == PREC_NONE);
            cc_bad = to_cc && (|idx);
         end
      end else begin : g_src
         always_comb begin
            to_cc  = 1'b0;
            cc_bad = 1'b0;
         end
      end
   endgenerate

   assign bad = active && (align_bad || cc_bad);

endmodule

// File: rtl/fpop_decoder.sv
module fpop_decoder
   import fpop_pkg::*;
#(
   parameter int unsigned WORD_BITS   = WORD_W,
   parameter int unsigned REG_BITS    = IDX_W,
   parameter int unsigned TRAP_BITS   = 3,
   parameter int unsigned BADREG_CODE = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [WORD_BITS-1:0]  in_word,
   output logic                  out_valid,
   output logic [3:0]            out_kind,
   output logic [1:0]            out_prec_rs1,
   output logic [1:0]            out_prec_rs2,
   output logic [1:0]            out_prec_rd,
   output logic [REG_BITS-1:0]   out_idx_rs1,
   output logic [REG_BITS-1:0]   out_idx_rs2,
   output logic [REG_BITS-1:0]   out_idx_rd,
   output logic                  out_rd_cc,
   output logic                  out_err_unknown,
   output logic                  out_err_badreg,
   output logic [TRAP_BITS-1:0]  out_trap
);

   localparam logic [TRAP_BITS-1:0] TRAP_BAD  = TRAP_BITS'(BADREG_CODE);
   localparam logic [TRAP_BITS-1:0] TRAP_NONE = '0;
   localparam int unsigned          RD_SLOT   = N_OPND - 1;

   generate
      if (WORD_BITS != WORD_W) begin : g_bad_word
         $error("fpop_decoder: word width must match the field layout");
      end
      if (REG_BITS != IDX_W) begin : g_bad_reg
         $error("fpop_decoder: register index width must be 5");
      end
      if (BADREG_CODE == 0 || BADREG_CODE >= (1 << TRAP_BITS)) begin : g_bad_trap
         $error("fpop_decoder: trap code must be nonzero and fit the field");
      end
   endgenerate

   logic is_arith;
   logic is_cmp;
   entry_t ent;

   fpop_class_match #(.W(WORD_BITS)) u_class (
      .word     (in_word),
      .is_arith (is_arith),
      .is_cmp   (is_cmp)
   );

   fpop_opf_table #(.OW(OPF_W)) u_table (
      .is_arith (is_arith),
      .is_cmp   (is_cmp),
      .opf      (in_word[OPF_LSB +: OPF_W]),
      .entry    (ent)
   );

   logic [N_OPND-1:0][1:0]          slot_prec;
   logic [N_OPND-1:0][REG_BITS-1:0] slot_idx;
   logic [N_OPND-1:0]               slot_bad;
   logic [N_OPND-1:0]               slot_cc;

   always_comb begin
      slot_prec[0] = ent.p_rs1;
      slot_prec[1] = ent.p_rs2;
      slot_prec[2] = ent.p_rd;
      slot_idx[0]  = in_word[RS1_LSB +: REG_BITS];
      slot_idx[1]  = in_word[RS2_LSB +: REG_BITS];
      slot_idx[2]  = in_word[RD_LSB  +: REG_BITS];
   end

   // All slots are checked side by side; any fault yields the same code,
   // so no ordering between slots is needed.
   generate
      for (genvar g = 0; g < N_OPND; g++) begin : g_slot
         fpop_reg_check #(
            .IW      (REG_BITS),
            .IS_DEST (g == RD_SLOT)
         ) u_chk (
            .active (ent.hit),
            .prec   (slot_prec[g]),
            .idx    (slot_idx[g]),
            .bad    (slot_bad[g]),
            .to_cc  (slot_cc[g])
         );
      end
   endgenerate

   logic                 any_bad;
   logic                 dest_cc;
   logic [TRAP_BITS-1:0] trap_next;

   always_comb begin
      any_bad   = |slot_bad;
      dest_cc   = |slot_cc;
      trap_next = any_bad ? TRAP_BAD : TRAP_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_kind        <= '0;
         out_prec_rs1    <= '0;
         out_prec_rs2    <= '0;
         out_prec_rd     <= '0;
         out_idx_rs1     <= '0;
         out_idx_rs2     <= '0;
         out_idx_rd      <= '0;
         out_rd_cc       <= 1'b0;
         out_err_unknown <= 1'b0;
         out_err_badreg  <= 1'b0;
         out_trap        <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_kind        <= ent.kind;
            out_prec_rs1    <= slot_prec[0];
            out_prec_rs2    <= slot_prec[1];
            out_prec_rd     <= slot_prec[2];
            out_idx_rs1     <= slot_idx[0];
            out_idx_rs2     <= slot_idx[1];
            out_idx_rd      <= slot_idx[2];
            out_rd_cc       <= dest_cc;
            out_err_unknown <= !ent.hit;
            out_err_badreg  <= any_bad;
            out_trap        <= trap_next;
         end
      end
   end

endmodule

// File: rtl/fpop_decoder_chk.sv
module fpop_decoder_chk
   import fpop_pkg::*;
#(
   parameter int unsigned WORD_BITS = WORD_W,
   parameter int unsigned REG_BITS  = IDX_W,
   parameter int unsigned TRAP_BITS = 3,
   parameter int unsigned BADREG_CODE = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [WORD_BITS-1:0] in_word,
   input logic                 out_valid,
   input logic [3:0]           out_kind,
   input logic [1:0]           out_prec_rs1,
   input logic [1:0]           out_prec_rs2,
   input logic [1:0]           out_prec_rd,
   input logic [REG_BITS-1:0]  out_idx_rs1,
   input logic [REG_BITS-1:0]  out_idx_rs2,
   input logic [REG_BITS-1:0]  out_idx_rd,
   input logic                 out_rd_cc,
   input logic                 out_err_unknown,
   input logic                 out_err_badreg,
   input logic [TRAP_BITS-1:0] out_trap
);

   localparam logic [TRAP_BITS-1:0] TRAP_BAD = TRAP_BITS'(BADREG_CODE);

   // R2: an unknown word carries no operation and no trap
   p_unknown_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_err_unknown |-> (out_kind == 4'd0 && out_trap == '0 && !out_rd_cc));

   // R8: at most one error cause
   p_one_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_err_unknown, out_err_badreg}));

   // R8: trap code follows the register error
   p_trap_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_err_badreg ? (out_trap == TRAP_BAD) : (out_trap == '0)));

   // R5: a clean quad source is aligned to four
   p_quad_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err_badreg && out_prec_rs2 == 2'b11) |-> (out_idx_rs2[1:0] == 2'b00));

   // R6: a clean double destination is even
   p_dbl_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_err_badreg && out_prec_rd == 2'b10) |-> (out_idx_rd[0] == 1'b0));

   // R7: condition-code destination only for compares, with rd precision 00
   p_cc_dest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_rd_cc |-> (out_prec_rd == 2'b00 && (out_kind == 4'd11 || out_kind == 4'd12)));

   // R9: one-cycle latency of the valid strobe
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9: outputs hold without a strobe
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_kind) && $stable(out_trap) && $stable(out_idx_rd)
                     && $stable(out_err_unknown) && $stable(out_err_badreg)));

   // R4: register index fields are carried through
   p_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_idx_rs1 == $past(in_word[RS1_LSB +: REG_BITS])
                    && out_idx_rs2 == $past(in_word[RS2_LSB +: REG_BITS])
                    && out_idx_rd  == $past(in_word[RD_LSB  +: REG_BITS])));

endmodule

bind fpop_decoder fpop_decoder_chk #(
   .WORD_BITS   (WORD_BITS),
   .REG_BITS    (REG_BITS),
   .TRAP_BITS   (TRAP_BITS),
   .BADREG_CODE (BADREG_CODE)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .in_valid        (in_valid),
   .in_word         (in_word),
   .out_valid       (out_valid),
   .out_kind        (out_kind),
   .out_prec_rs1    (out_prec_rs1),
   .out_prec_rs2    (out_prec_rs2),
   .out_prec_rd     (out_prec_rd),
   .out_idx_rs1     (out_idx_rs1),
   .out_idx_rs2     (out_idx_rs2),
   .out_idx_rd      (out_idx_rd),
   .out_rd_cc       (out_rd_cc),
   .out_err_unknown (out_err_unknown),
   .out_err_badreg  (out_err_badreg),
   .out_trap        (out_trap)
);

// File: tb/fpop_decoder_tb.sv
`timescale 1ns/1ps
module fpop_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic [3:0]  out_kind;
   logic [1:0]  out_prec_rs1, out_prec_rs2, out_prec_rd;
   logic [4:0]  out_idx_rs1, out_idx_rs2, out_idx_rd;
   logic        out_rd_cc, out_err_unknown, out_err_badreg;
   logic [2:0]  out_trap;

   always #10 clk = ~clk;

   fpop_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
      .out_valid(out_valid), .out_kind(out_kind),
      .out_prec_rs1(out_prec_rs1), .out_prec_rs2(out_prec_rs2), .out_prec_rd(out_prec_rd),
      .out_idx_rs1(out_idx_rs1), .out_idx_rs2(out_idx_rs2), .out_idx_rd(out_idx_rd),
      .out_rd_cc(out_rd_cc), .out_err_unknown(out_err_unknown),
      .out_err_badreg(out_err_badreg), .out_trap(out_trap)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // expected registered state
   int e_valid = 0, e_kind = 0, e_p1 = 0, e_p2 = 0, e_pd = 0;
   int e_i1 = 0, e_i2 = 0, e_id = 0, e_cc = 0, e_unk = 0, e_breg = 0, e_trap = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R9", "valid", int'(out_valid), e_valid);
      chk("R3", "kind", int'(out_kind), e_kind);
      chk("R3", "prec_rs1", int'(out_prec_rs1), e_p1);
      chk("R3", "prec_rs2", int'(out_prec_rs2), e_p2);
      chk("R7", "prec_rd", int'(out_prec_rd), e_pd);
      chk("R4", "idx_rs1", int'(out_idx_rs1), e_i1);
      chk("R4", "idx_rs2", int'(out_idx_rs2), e_i2);
      chk("R4", "idx_rd", int'(out_idx_rd), e_id);
      chk("R7", "rd_cc", int'(out_rd_cc), e_cc);
      chk("R1", "err_unknown", int'(out_err_unknown), e_unk);
      chk("R5", "err_badreg", int'(out_err_badreg), e_breg);
      chk("R8", "trap", int'(out_trap), e_trap);
   endtask

   function automatic bit misplaced(int p, int idx, bit dest);
      if (p == 3) return (idx % 4) != 0;
      if (p == 2) return (idx % 2) != 0;
      if (p == 0 && dest) return idx != 0;
      return 1'b0;
   endfunction

   // behavioural reference decode
   task automatic ref_decode(input logic [31:0] w);
      int op, k, a, b, d, lo;
      bit hit, arith, cmpc;
      op    = int'(w[13:5]);
      lo    = op % 4;
      arith = ((w & 32'hC1F8_0000) == 32'h81A0_0000);
      cmpc  = ((w & 32'hC1F8_0000) == 32'h81A8_0000);
      hit = 1'b1; k = 0; a = 0; b = 0; d = 0;
      if (arith) begin
         if (op == 1 || op == 5 || op == 9) begin
            k = (op == 1) ? 1 : (op == 5) ? 2 : 3; b = 1; d = 1;
         end else if (op >= 'h29 && op <= 'h2B) begin
            k = 8; b = lo; d = lo;
         end else if (op >= 'h41 && op <= 'h4F && lo != 0) begin
            k = 4 + (op - 'h40) / 4; a = lo; b = lo; d = lo;
         end else if (op == 'h69) begin
            k = 9; a = 1; b = 1; d = 2;
         end else if (op == 'h6E) begin
            k = 9; a = 2; b = 2; d = 3;
         end else begin
            k = 10;
            case (op)
               'hC6: begin b = 2; d = 1; end
               'hC7: begin b = 3; d = 1; end
               'hC9: begin b = 1; d = 2; end
               'hCB: begin b = 3; d = 2; end
               'hCC, 'hCD: begin b = 1; d = 3; end
               'hCE: begin b = 2; d = 3; end
               'hD1: begin b = 1; d = 1; end
               'hD2: begin b = 2; d = 1; end
               'hD3: begin b = 3; d = 1; end
               default: hit = 1'b0;
            endcase
         end
      end else if (cmpc) begin
         if (op >= 'h51 && op <= 'h53) begin k = 11; a = lo; b = lo; end
         else if (op >= 'h55 && op <= 'h57) begin k = 12; a = lo; b = lo; end
         else hit = 1'b0;
      end else begin
         hit = 1'b0;
      end
      if (!hit) begin k = 0; a = 0; b = 0; d = 0; end
      e_kind = k; e_p1 = a; e_p2 = b; e_pd = d;
      e_i1 = int'(w[18:14]); e_i2 = int'(w[4:0]); e_id = int'(w[29:25]);
      e_unk = hit ? 0 : 1;
      e_cc  = (hit && d == 0) ? 1 : 0;
      e_breg = (hit && (misplaced(a, e_i1, 1'b0) || misplaced(b, e_i2, 1'b0)
                        || misplaced(d, e_id, 1'b1))) ? 1 : 0;
      e_trap = e_breg ? 6 : 0;
   endtask

   function automatic logic [31:0] mkw(bit cmpc, int op, int rd, int rs1, int rs2);
      return {2'b10, 5'(rd), (cmpc ? 6'b110101 : 6'b110100), 5'(rs1), 9'(op), 5'(rs2)};
   endfunction

   // drive at negedge, model updates at the edge, compare at next negedge
   task automatic step(input bit v, input logic [31:0] w);
      in_valid = v;
      in_word  = w;
      @(posedge clk);
      if (v) ref_decode(w);
      e_valid = v ? 1 : 0;
      @(negedge clk);
      compare_all();
   endtask

   logic [31:0] lfsr = 32'h1357_9BDF;
   function automatic logic [31:0] nxt(logic [31:0] s);
      logic [31:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   int ar_ops[36] = '{'h001,'h005,'h009,'h029,'h02A,'h02B,'h041,'h042,'h043,'h045,
                      'h046,'h047,'h049,'h04A,'h04B,'h04D,'h04E,'h04F,'h069,'h06E,
                      'h0C6,'h0C7,'h0C9,'h0CB,'h0CC,'h0CD,'h0CE,'h0D1,'h0D2,'h0D3,
                      'h051,'h052,'h053,'h055,'h056,'h057};

   initial begin
      repeat (3) @(negedge clk);
      // R10: everything zero in reset
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R3: single add, aligned
      step(1, mkw(0, 'h041, 3, 5, 7));
      // R6: double add with odd rs1
      step(1, mkw(0, 'h042, 2, 3, 4));
      // R5: quad add with rs2 = 2
      step(1, mkw(0, 'h043, 4, 8, 2));
      // R5: clean quad add
      step(1, mkw(0, 'h043, 12, 16, 28));
      // R9: idle cycles must hold
      step(0, 32'hFFFF_FFFF);
      step(0, mkw(0, 'h042, 1, 1, 1));
      // R7: compare to cc with rd 0, and with nonzero rd plus misaligned source
      step(1, mkw(1, 'h053, 0, 4, 8));
      step(1, mkw(1, 'h057, 1, 1, 8));
      // R2: compare opcode in the arithmetic class is unknown, no trap
      step(1, mkw(0, 'h051, 1, 3, 3));
      // R2: arithmetic opcode in the compare class
      step(1, mkw(1, 'h043, 1, 1, 1));
      // R1: class mismatch
      step(1, mkw(0, 'h041, 0, 0, 0) ^ 32'h4000_0000);
      // R8: clean word after a trap clears the code
      step(1, mkw(0, 'h069, 3, 5, 7));
      step(1, mkw(0, 'h06E, 4, 2, 6));
      step(1, mkw(0, 'h06E, 6, 2, 6));
      step(1, mkw(0, 'h0CE, 8, 31, 2));

      for (int i = 0; i < 600; i++) begin
         int mode, sel;
         lfsr = nxt(lfsr);
         mode = int'(lfsr[1:0]);
         sel  = int'(lfsr[31:8] % 36);
         if (mode == 0) begin
            step(lfsr[2], nxt(lfsr));
         end else begin
            logic [31:0] r;
            int rd;
            r  = nxt(lfsr);
            rd = (sel >= 30 && r[20]) ? 0 : int'(r[29:25]);
            step(lfsr[3] | lfsr[4], mkw(sel >= 30, ar_ops[sel], rd, int'(r[18:14]), int'(r[4:0])));
         end
      end
      step(0, '0);

      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL R9 watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule